// File: doc/BRIEF.md
# Projective Differential Point Addition Step over GF(2^m)

This block performs one x-only differential addition step in projective coordinates over a binary field GF(2^m). Given the running pair (X1, Z1), the companion pair (X2, Z2) and the affine base coordinate xP, it returns an updated pair. The new Z1 is the square of (X1·Z2 + X2·Z1). The new X1 is xP·Z1new + (X1·Z2)·(X2·Z1). Addition in the field is bitwise XOR.

The four field products come from four bit-serial multipliers inside the block, run as two phases of two multipliers each. The first phase forms T1 = X1·Z2 and T2 = X2·Z1. The second phase forms xP·Z1new and T1·T2, and it may only begin once both first-phase products are ready. Squaring is combinational. A surrounding scalar sequencer decides when to request a step and owns the key bits. It pulses the start input and waits for the done pulse.

Top module: `padd_unit`

## Requirements
- R1: After a step, `z1_o` equals (X1·Z2 XOR X2·Z1)^2 in GF(2^m) modulo the parameter polynomial (default x^163 + x^7 + x^6 + x^3 + 1).
- R2: After a step, `x1_o` equals xP·z1_o XOR (X1·Z2)·(X2·Z1) in the same field.
- R3: `done_o` is high for exactly one cycle. It rises 2·M+2 clock edges after the edge that samples an accepted `start_i`.
- R4: A `start_i` pulse that arrives while a step is in progress is ignored. Neither the timing nor the result of the running step changes.
- R5: `x1_o` and `z1_o` change only in the cycle in which `done_o` is high. At all other times they hold their values.
- R6: A synchronous active-high reset clears `x1_o`, `z1_o` and `done_o` to zero and makes the unit idle.
- R7: Each multiplier takes exactly M cycles per product. It consumes one bit of the second operand per cycle, least significant bit first, and then gives a one-cycle done pulse.
- R8: The second-phase multipliers start only when both first-phase multipliers have finished.
- R9: Zero operands are handled: with Z1 = Z2 = 0 both outputs are zero, and with xP = 0 the result x1_o reduces to T1·T2.
- R10: Squaring reduces every product bit above position M-1 through the polynomial. An input with its top bits set therefore produces a correctly reduced Z1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one step; sampled only when idle |
| x1_i | input | M | Running X coordinate |
| z1_i | input | M | Running Z coordinate |
| x2_i | input | M | Companion X coordinate |
| z2_i | input | M | Companion Z coordinate |
| xp_i | input | M | Affine base x coordinate |
| x1_o | output | M | Updated X1 (registered) |
| z1_o | output | M | Updated Z1 (registered) |
| done_o | output | 1 | One-cycle pulse when the outputs are updated |

## Verification
The bench builds the unit with its default parameters: M = 163 and the pentanomial x^163 + x^7 + x^6 + x^3 + 1. Full-width random operands therefore set bits near the top of the field, and the reduction paths in both squaring and multiplication get exercised. The reference multiplies most-significant-bit first, the opposite direction to the hardware, so a mistake in reduction order or bit consumption shows as a mismatch. The 2·163+2 cycle latency is tracked cycle by cycle. This makes the single-pulse done, the hold of the outputs between steps and the discarding of a mid-step start observable at the ports.

// File: rtl/padd_pkg.sv
package padd_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_PH1  = 2'd1,
    PS_PH2  = 2'd2
  } padd_state_t;

  localparam int unsigned PADD_NMUL = 4;

endpackage

// File: rtl/padd_gf_sqr.sv
module padd_gf_sqr #(
  parameter int unsigned M = 163,
  parameter logic [M-1:0] POLY = {{(M-8){1'b0}}, 8'hC9}
) (
  input  logic [M-1:0] a_i,
  output logic [M-1:0] y_o
);
  localparam int unsigned W = 2*M - 1;
  localparam logic [W-1:0] PFULL = (W'(1) << M) | W'(POLY);

  logic [W-1:0] wide;

  // R10: spread to even positions, then fold the top down through the polynomial
  always_comb begin
    wide = '0;
    for (int i = 0; i < M; i++) wide[2*i] = a_i[i];
    for (int i = W - 1; i >= M; i--) begin
      if (wide[i]) wide = wide ^ (PFULL << (i - M));
    end
    y_o = wide[M-1:0];
  end

endmodule

// File: rtl/padd_gf_mul.sv
module padd_gf_mul #(
  parameter int unsigned M = 163,
  parameter logic [M-1:0] POLY = {{(M-8){1'b0}}, 8'hC9}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [M-1:0] p_o
);
  localparam int unsigned CW = $clog2(M + 1);

  logic [M-1:0]  a_q, b_q, acc_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  function automatic logic [M-1:0] mul_x(input logic [M-1:0] v);
    logic [M-1:0] s;
    s = {v[M-2:0], 1'b0};
    if (v[M-1]) s = s ^ POLY;
    return s;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          a_q    <= a_i;
          b_q    <= b_i;
          acc_q  <= '0;
          cnt_q  <= '0;
          busy_q <= 1'b1;
        end
      end else begin
        // R7: one bit of b per cycle, LSB first
        if (b_q[0]) acc_q <= acc_q ^ a_q;
        a_q   <= mul_x(a_q);
        b_q   <= {1'b0, b_q[M-1:1]};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(M - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign p_o    = acc_q;

  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q < CW'(M)));
  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q)));
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r7_start_loads: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_q) |=> (busy_q && cnt_q == '0));

endmodule

// File: rtl/padd_unit.sv
module padd_unit
  import padd_pkg::*;
#(
  parameter int unsigned M = 163,
  parameter logic [M-1:0] POLY = {{(M-8){1'b0}}, 8'hC9}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [M-1:0] x1_i,
  input  logic [M-1:0] z1_i,
  input  logic [M-1:0] x2_i,
  input  logic [M-1:0] z2_i,
  input  logic [M-1:0] xp_i,
  output logic [M-1:0] x1_o,
  output logic [M-1:0] z1_o,
  output logic         done_o
);
  localparam int unsigned NM = PADD_NMUL;

  padd_state_t st_q;
  logic [M-1:0] xp_q, z1n_q, z1n;
  logic [1:0]   seen_q;
  logic [NM-1:0][M-1:0] opa, opb, prod;
  logic [NM-1:0] mstart, mbusy, mdone;
  logic go, both1, both2, adv1, adv2;

  assign go    = (st_q == PS_IDLE) && start_i;
  assign both1 = (seen_q[0] | mdone[0]) & (seen_q[1] | mdone[1]);
  assign both2 = (seen_q[0] | mdone[2]) & (seen_q[1] | mdone[3]);
  assign adv1  = (st_q == PS_PH1) && both1;  // R8
  assign adv2  = (st_q == PS_PH2) && both2;

  // phase one: T1 = X1*Z2, T2 = X2*Z1 ; phase two: xP*Z1new, T1*T2
  assign opa[0] = x1_i;     assign opb[0] = z2_i;
  assign opa[1] = x2_i;     assign opb[1] = z1_i;
  assign opa[2] = xp_q;     assign opb[2] = z1n;
  assign opa[3] = prod[0];  assign opb[3] = prod[1];
  assign mstart = {adv1, adv1, go, go};

  padd_gf_sqr #(.M(M), .POLY(POLY)) u_sqr (
    .a_i (prod[0] ^ prod[1]),
    .y_o (z1n)
  );

  for (genvar g = 0; g < NM; g++) begin : g_mul
    padd_gf_mul #(.M(M), .POLY(POLY)) u_mul (
      .clk     (clk),
      .rst     (rst),
      .start_i (mstart[g]),
      .a_i     (opa[g]),
      .b_i     (opb[g]),
      .busy_o  (mbusy[g]),
      .done_o  (mdone[g]),
      .p_o     (prod[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PS_IDLE;
      xp_q   <= '0;
      z1n_q  <= '0;
      seen_q <= '0;
      x1_o   <= '0;
      z1_o   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        PS_IDLE: if (go) begin
          xp_q   <= xp_i;
          seen_q <= '0;
          st_q   <= PS_PH1;
        end
        PS_PH1: begin
          seen_q <= seen_q | mdone[1:0];
          if (adv1) begin
            z1n_q  <= z1n;
            seen_q <= '0;
            st_q   <= PS_PH2;
          end
        end
        PS_PH2: begin
          seen_q <= seen_q | mdone[3:2];
          if (adv2) begin
            x1_o   <= prod[2] ^ prod[3];
            z1_o   <= z1n_q;
            done_o <= 1'b1;
            seen_q <= '0;
            st_q   <= PS_IDLE;
          end
        end
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  a_r8_phase_order: assert property (@(posedge clk) disable iff (rst)
    (mstart[2] || mstart[3]) |-> (!mbusy[0] && !mbusy[1]));
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r4_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (st_q != PS_IDLE && !done_o) |=> $stable(xp_q));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!done_o && !$past(rst)) |-> ($stable(x1_o) && $stable(z1_o)));
  a_r6_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!done_o && x1_o == '0 && z1_o == '0));

endmodule

// File: tb/test_padd_unit.sv
module test_padd_unit;
  localparam int unsigned M = 163;
  localparam logic [M-1:0] POLY = {{(M-8){1'b0}}, 8'hC9};
  localparam int LAT = 2*M + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [M-1:0] x1_i = '0, z1_i = '0, x2_i = '0, z2_i = '0, xp_i = '0;
  logic [M-1:0] x1_o, z1_o;
  logic done_o;

  int checks = 0, errors = 0, cyc = 0, due = 0;
  bit pending = 0, mon_en = 0, finished = 0;
  logic [M-1:0] nx, nz, hold_x, hold_z;

  always #5 clk = ~clk;

  padd_unit #(.M(M), .POLY(POLY)) i_padd_unit (
    .clk(clk), .rst(rst), .start_i(start_i),
    .x1_i(x1_i), .z1_i(z1_i), .x2_i(x2_i), .z2_i(z2_i), .xp_i(xp_i),
    .x1_o(x1_o), .z1_o(z1_o), .done_o(done_o)
  );

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = {r[M-2:0], 1'b0} ^ (r[M-1] ? POLY : '0);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [M-1:0] rnd_elem();
    logic [M-1:0] v;
    v = '0;
    for (int i = 0; i < M; i += 32) v = v ^ (M'($urandom) << i);
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // cycle-by-cycle reference: acceptance, done timing, output hold
  always @(negedge clk) begin
    if (mon_en) begin
      if (pending && cyc == due) begin
        hold_x = nx; hold_z = nz; pending = 0;
        chk(done_o === 1'b1, "R3 R7 done at 2M+2", M'(done_o), M'(1));
      end else begin
        chk(done_o === 1'b0, "R3 no done", M'(done_o), M'(0));
      end
      chk(x1_o === hold_x, "R5 x1 hold/update", x1_o, hold_x);
      chk(z1_o === hold_z, "R5 z1 hold/update", z1_o, hold_z);
      if (start_i && !pending) begin
        logic [M-1:0] t1, t2, s;
        t1 = ref_mul(x1_i, z2_i);
        t2 = ref_mul(x2_i, z1_i);
        s  = t1 ^ t2;
        nz = ref_mul(s, s);
        nx = ref_mul(xp_i, nz) ^ ref_mul(t1, t2);
        due = cyc + 1 + LAT;
        pending = 1;
      end
    end
  end

  task automatic step(input string tag, input logic [M-1:0] a, b, c, d, p, input bit poke);
    logic [M-1:0] ex, ez, t1, t2;
    t1 = ref_mul(a, d); t2 = ref_mul(c, b);
    ez = ref_mul(t1 ^ t2, t1 ^ t2);
    ex = ref_mul(p, ez) ^ ref_mul(t1, t2);
    @(posedge clk); #2;
    x1_i = a; z1_i = b; x2_i = c; z2_i = d; xp_i = p; start_i = 1;
    @(posedge clk); #2;
    start_i = 0;
    if (poke) begin
      repeat (20) @(posedge clk);
      #2;
      x1_i = rnd_elem(); z1_i = rnd_elem(); x2_i = rnd_elem(); z2_i = rnd_elem(); xp_i = rnd_elem();
      start_i = 1;
      @(posedge clk); #2;
      start_i = 0;
    end
    while (pending) @(posedge clk);
    #2;
    chk(z1_o === ez, {tag, " z1"}, z1_o, ez);
    chk(x1_o === ex, {tag, " x1"}, x1_o, ex);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R6 reset state
    chk(x1_o === '0, "R6 x1 reset", x1_o, '0);
    chk(z1_o === '0, "R6 z1 reset", z1_o, '0);
    chk(done_o === 1'b0, "R6 done reset", M'(done_o), '0);
    rst = 0;
    hold_x = '0; hold_z = '0;
    mon_en = 1;
    step("R1 R2 small", M'(3), M'(1), M'(2), M'(1), M'(5), 0);
    step("R9 zero Z", rnd_elem(), '0, rnd_elem(), '0, rnd_elem(), 0);
    step("R9 zero xP", rnd_elem(), rnd_elem(), rnd_elem(), rnd_elem(), '0, 0);
    step("R10 top bits", {M{1'b1}}, {1'b1, {(M-1){1'b0}}}, {2'b11, {(M-2){1'b0}}}, {M{1'b1}}, {M{1'b1}}, 0);
    for (int k = 0; k < 4; k++)
      step("R1 R2 R7 R8 random", rnd_elem(), rnd_elem(), rnd_elem(), rnd_elem(), rnd_elem(), 0);
    step("R4 ignored start", rnd_elem(), rnd_elem(), rnd_elem(), rnd_elem(), rnd_elem(), 1);
    repeat (5) @(posedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule